// File: doc/BRIEF.md
# Serial EEPROM Command Engine

This block is the byte-level sequencer of a two-wire slave memory holding 256 bytes of 8 bits. A bus front end that is not part of this block turns pad activity into single-cycle events: a start (or repeated start), a stop, a complete byte from the master, the master's acknowledge after a byte the slave sent, and a request for the next byte to transmit. The engine answers each received byte with an acknowledge decision and each transmit request with a data byte, one clock later in both cases.

A transaction opens with a device-select byte. It is checked against a fixed type code and three chip-enable pins. On a write, the next byte sets the address and the following bytes fill a 16-byte page buffer. On the closing stop, a self-timed write cycle copies the buffer into the array. While that cycle runs, the engine acknowledges nothing, so a master can poll by repeating the device select until it is acknowledged. Reads return bytes from an internal address counter, which wraps over the whole array. An external enable input protects the lower half of the array against writes.

Top module: `serial_eeprom_engine`

## Requirements
- R1: After reset, busy, ack_vld and tx_vld are 0. Every array byte reads FFh until it is first written.
- R2: A device-select byte has the type code 1010 in bits 7:4, the chip-enable bits 3:1 compared with chip_en[2:0] bit for bit, and the direction in bit 0 (1 = read). A select that matches is acknowledged. A select with a wrong type or chip-enable value is not acknowledged. After it, no byte is acknowledged and no transmit request is served until the next start.
- R3: Every received byte is followed, exactly one cycle later, by a single-cycle ack_vld pulse. When that pulse is present, ack is 1 for an acknowledge and 0 otherwise.
- R4: After a write select, the first byte sets the address and is acknowledged. Each following data byte is acknowledged and goes to the current address. After each data byte only the low 4 address bits advance, wrapping within the 16-byte page while the upper 4 bits stay fixed. The stored data appears in the array only after the closing stop.
- R5: A stop that ends a write with at least one accepted data byte raises busy for exactly max(WR_CYCLES,16) cycles, starting the cycle after the stop. While busy is high, no byte is acknowledged. A stop after only an address byte does not raise busy.
- R6: A current-address read returns the byte at the internal counter. After a write, the counter holds the last written address plus one within its page.
- R7: A repeated start after a write select discards the data bytes received since that select, and nothing is written. A write select plus an address followed by a repeated start and a read select reads from that address.
- R8: During a read, the counter increments after each byte sent and rolls over from FFh to 00h.
- R9: A master no-acknowledge after a read byte ends the transfer. Later transmit requests and received bytes get no response until the next start.
- R10: While wp_en is 1, a data byte addressed to 00h–7Fh is not acknowledged and not stored. Addresses 80h–FFh are unaffected.
- R11: A transmit request during a read gives a one-cycle tx_vld pulse with tx_data the next cycle. No tx_vld appears without such a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_start | input | 1 | Start or repeated start seen on the bus |
| ev_stop | input | 1 | Stop seen on the bus |
| ev_byte_valid | input | 1 | A byte from the master is complete |
| ev_byte | input | 8 | The received byte |
| ev_mack_valid | input | 1 | The master's acknowledge bit after a sent byte was sampled |
| ev_mack | input | 1 | 1 when the master acknowledged |
| ev_tx_req | input | 1 | Front end asks for the next byte to send |
| chip_en | input | 3 | Chip-enable pins |
| wp_en | input | 1 | Write protection of the lower half |
| ack_vld | output | 1 | Acknowledge decision is valid |
| ack | output | 1 | 1 = acknowledge the byte |
| tx_vld | output | 1 | tx_data is valid |
| tx_data | output | 8 | Byte to shift out |
| busy | output | 1 | Self-timed write cycle in progress |

## Verification
The bench runs directed transactions that separate the address behaviours. A page write that starts near the page end shows page wrap apart from full-array increment. A read that crosses FFh shows rollover apart from page wrap. A repeated start after buffered data shows discard apart from commit. It then sends selects with a wrong type code and wrong chip-enable bits, protected and unprotected writes, and polls during the write cycle. Random page writes of 1 to 20 bytes, so that some overrun a page, are read back with random reads at random addresses. These compare the buffer drain and the counter against a bench model of the array.

// File: rtl/see_pkg.sv
package see_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA
  } see_state_e;

  typedef logic [7:0] see_byte_t;
endpackage

// File: rtl/see_ram.sv
module see_ram #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/see_page_buf.sv
module see_page_buf #(
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              we,
  input  logic [PAGE_W-1:0] widx,
  input  logic [7:0]        wdata,
  input  logic [PAGE_W-1:0] ridx,
  output logic [7:0]        rdata,
  output logic              rvalid,
  output logic              any
);
  localparam int PAGE = 1 << PAGE_W;

  logic [7:0]      slot [PAGE];
  logic [PAGE-1:0] filled;

  always_ff @(posedge clk) begin
    if (we) slot[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) filled <= '0;
    else if (we)    filled[widx] <= 1'b1;
  end

  assign rdata  = slot[ridx];
  assign rvalid = filled[ridx];
  assign any    = |filled;
endmodule

// File: rtl/serial_eeprom_engine.sv
module serial_eeprom_engine #(
  parameter int          ADDR_W    = 8,
  parameter int          PAGE_W    = 4,
  parameter int          WR_CYCLES = 64,
  parameter logic [3:0]  DEV_TYPE  = 4'b1010
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic       ev_byte_valid,
  input  logic [7:0] ev_byte,
  input  logic       ev_mack_valid,
  input  logic       ev_mack,
  input  logic       ev_tx_req,
  input  logic [2:0] chip_en,
  input  logic       wp_en,
  output logic       ack_vld,
  output logic       ack,
  output logic       tx_vld,
  output logic [7:0] tx_data,
  output logic       busy
);
  import see_pkg::*;

  localparam int PAGE     = 1 << PAGE_W;
  localparam int BUSY_LEN = (WR_CYCLES > PAGE) ? WR_CYCLES : PAGE;
  localparam int CNT_W    = $clog2(BUSY_LEN) + 1;
  localparam int HI_W     = ADDR_W - PAGE_W;

  see_state_e        state;
  logic [ADDR_W-1:0] addr;
  logic [CNT_W-1:0]  cnt;

  // Decode of the current event against the state
  logic sel_match, in_wdata, prot, pb_we, pb_clr, pb_any;
  logic rd_en, drain_on, drain_we;
  logic [PAGE_W-1:0] drain_idx;
  logic [7:0]        drain_data;
  logic              drain_valid;

  assign sel_match = (ev_byte[7:4] == DEV_TYPE) && (ev_byte[3:1] == chip_en);
  assign in_wdata  = (state == ST_WDATA) && !busy;
  assign prot      = wp_en && !addr[ADDR_W-1];
  assign pb_we     = ev_byte_valid && in_wdata && !prot && !ev_start && !ev_stop;
  assign pb_clr    = ev_start && !busy;
  assign rd_en     = ev_tx_req && (state == ST_RDATA) && !busy
                     && !ev_start && !ev_stop;

  assign drain_on  = busy && (cnt < CNT_W'(PAGE));
  assign drain_idx = cnt[PAGE_W-1:0];
  assign drain_we  = drain_on && drain_valid;

  see_page_buf #(.PAGE_W(PAGE_W)) u_buf (
    .clk    (clk),
    .rst    (rst),
    .clr    (pb_clr),
    .we     (pb_we),
    .widx   (addr[PAGE_W-1:0]),
    .wdata  (ev_byte),
    .ridx   (drain_idx),
    .rdata  (drain_data),
    .rvalid (drain_valid),
    .any    (pb_any)
  );

  see_ram #(.ADDR_W(ADDR_W)) u_ram (
    .clk   (clk),
    .we    (drain_we),
    .waddr ({addr[ADDR_W-1:PAGE_W], drain_idx}),
    .wdata (drain_data),
    .re    (rd_en),
    .raddr (addr),
    .rdata (tx_data)
  );

  // Write-cycle timer
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (cnt == CNT_W'(BUSY_LEN - 1)) busy <= 1'b0;
    end else if (ev_stop && state == ST_WDATA && pb_any) begin
      busy <= 1'b1;
      cnt  <= '0;
    end
  end

  // Command sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      addr    <= '0;
      ack_vld <= 1'b0;
      ack     <= 1'b0;
      tx_vld  <= 1'b0;
    end else begin
      ack_vld <= ev_byte_valid;
      ack     <= 1'b0;
      tx_vld  <= 1'b0;
      if (busy) begin
        state <= ST_IDLE;
      end else if (ev_stop) begin
        state <= ST_IDLE;
      end else if (ev_start) begin
        state <= ST_SEL;
      end else begin
        if (ev_byte_valid) begin
          unique case (state)
            ST_SEL: begin
              if (sel_match) begin
                ack   <= 1'b1;
                state <= ev_byte[0] ? ST_RDATA : ST_ADDR;
              end else begin
                state <= ST_IDLE;
              end
            end
            ST_ADDR: begin
              ack   <= 1'b1;
              addr  <= ev_byte[ADDR_W-1:0];
              state <= ST_WDATA;
            end
            ST_WDATA: begin
              ack  <= !prot;
              addr <= {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + 1'b1};
            end
            default: ;
          endcase
        end
        if (rd_en) begin
          tx_vld <= 1'b1;
          addr   <= addr + 1'b1;
        end
        if (ev_mack_valid && !ev_mack && state == ST_RDATA) begin
          state <= ST_IDLE;
        end
      end
    end
  end

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = addr[ADDR_W-1:PAGE_W];
endmodule

// File: rtl/see_checker.sv
module see_checker (
  input logic clk,
  input logic rst,
  input logic ev_byte_valid,
  input logic ev_stop,
  input logic ev_tx_req,
  input logic ack_vld,
  input logic ack,
  input logic tx_vld,
  input logic busy
);
  a_r3_ack_follows_byte: assert property (@(posedge clk) disable iff (rst)
    ev_byte_valid |=> ack_vld);

  a_r3_ack_qualified: assert property (@(posedge clk) disable iff (rst)
    ack |-> ack_vld);

  a_r5_no_ack_busy: assert property (@(posedge clk) disable iff (rst)
    (ev_byte_valid && busy) |=> !ack);

  a_r5_busy_after_stop: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(ev_stop));

  a_r11_tx_needs_req: assert property (@(posedge clk) disable iff (rst)
    tx_vld |-> $past(ev_tx_req));
endmodule

bind serial_eeprom_engine see_checker u_chk (
  .clk           (clk),
  .rst           (rst),
  .ev_byte_valid (ev_byte_valid),
  .ev_stop       (ev_stop),
  .ev_tx_req     (ev_tx_req),
  .ack_vld       (ack_vld),
  .ack           (ack),
  .tx_vld        (tx_vld),
  .busy          (busy)
);

// File: tb/serial_eeprom_engine_tb_top.sv
module serial_eeprom_engine_tb_top;
  localparam int WR_CYCLES = 64;
  localparam int BUSY_LEN  = (WR_CYCLES > 16) ? WR_CYCLES : 16;
  localparam logic [2:0] PINS = 3'b101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_start = 0, ev_stop = 0, ev_byte_valid = 0, ev_mack_valid = 0;
  logic ev_mack = 0, ev_tx_req = 0, wp_en = 0;
  logic [7:0] ev_byte = 0;
  logic [2:0] chip_en = PINS;
  logic ack_vld, ack, tx_vld, busy;
  logic [7:0] tx_data;

  int unsigned n_chk = 0, n_bad = 0, cyc = 0;
  logic [7:0] exp_mem [256];
  logic [7:0] exp_addr;

  always #10 clk = ~clk;

  serial_eeprom_engine #(.WR_CYCLES(WR_CYCLES)) dut_i (
    .clk(clk), .rst(rst), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_byte_valid(ev_byte_valid), .ev_byte(ev_byte),
    .ev_mack_valid(ev_mack_valid), .ev_mack(ev_mack), .ev_tx_req(ev_tx_req),
    .chip_en(chip_en), .wp_en(wp_en), .ack_vld(ack_vld), .ack(ack),
    .tx_vld(tx_vld), .tx_data(tx_data), .busy(busy));

  function automatic logic [7:0] sel_byte(input logic [2:0] ce, input bit rd);
    return {4'b1010, ce, rd};
  endfunction

  function automatic logic [7:0] page_next(input logic [7:0] a);
    return {a[7:4], a[3:0] + 4'd1};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      summary();
    end
  end

  task automatic do_start();
    @(negedge clk); ev_start = 1;
    @(negedge clk); ev_start = 0;
  endtask

  task automatic do_stop();
    @(negedge clk); ev_stop = 1;
    @(negedge clk); ev_stop = 0;
  endtask

  task automatic send(input logic [7:0] b, input bit exp_ack, input string tag);
    @(negedge clk); ev_byte_valid = 1; ev_byte = b;
    @(negedge clk); ev_byte_valid = 0;
    chk(ack_vld === 1'b1 && ack === exp_ack, tag, {ack_vld, ack}, {1'b1, exp_ack});
  endtask

  task automatic rd(input bit mack, input logic [7:0] exp, input string tag);
    @(negedge clk); ev_tx_req = 1;
    @(negedge clk); ev_tx_req = 0;
    chk(tx_vld === 1'b1 && tx_data === exp, tag, {tx_vld, tx_data}, {1'b1, exp});
    @(negedge clk); ev_mack_valid = 1; ev_mack = mack;
    @(negedge clk); ev_mack_valid = 0;
  endtask

  task automatic no_tx(input string tag);
    @(negedge clk); ev_tx_req = 1;
    @(negedge clk); ev_tx_req = 0;
    chk(tx_vld === 1'b0, tag, tx_vld, 0);
  endtask

  task automatic wait_cycle(input string tag);
    chk(busy === 1'b1, tag, busy, 1);
    repeat (BUSY_LEN - 1) @(negedge clk);
    chk(busy === 1'b1, tag, busy, 1);
    @(negedge clk);
    chk(busy === 1'b0, tag, busy, 0);
  endtask

  // Random read of n bytes from a, last byte not acknowledged
  task automatic rand_read(input logic [7:0] a, input int n, input string tag);
    do_start();
    send(sel_byte(PINS, 0), 1, tag);
    send(a, 1, tag);
    do_start();
    send(sel_byte(PINS, 1), 1, tag);
    for (int i = 0; i < n; i++) begin
      logic [7:0] pa;
      pa = a + 8'(i);
      rd(i != n - 1, exp_mem[pa], tag);
    end
    do_stop();
    exp_addr = a + 8'(n);
  endtask

  task automatic page_write(input logic [7:0] a, input int n, input string tag);
    logic [7:0] pa;
    bit any;
    pa = a; any = 0;
    do_start();
    send(sel_byte(PINS, 0), 1, tag);
    send(a, 1, tag);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      bit p;
      d = 8'($urandom);
      p = wp_en && !pa[7];
      send(d, !p, tag);
      if (!p) begin exp_mem[pa] = d; any = 1; end
      pa = page_next(pa);
    end
    do_stop();
    exp_addr = pa;
    if (any) wait_cycle(tag);
    else chk(busy === 1'b0, tag, busy, 0);
  endtask

  initial begin
    void'($urandom(32'h5EE0_2024));
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(busy === 0 && ack_vld === 0 && tx_vld === 0, "R1 reset outputs",
        {busy, ack_vld, tx_vld}, 0);
    // R1, R8: blank array reads FFh
    rand_read(8'h10, 4, "R1 blank read");

    // R2: wrong chip-enable bits and wrong type code
    do_start();
    send(sel_byte(3'b100, 1), 0, "R2 chip-enable mismatch");
    no_tx("R2 no tx after mismatch");
    send(8'h00, 0, "R2 no ack after mismatch");
    do_start();
    send({4'b1011, PINS, 1'b0}, 0, "R2 type mismatch");
    send(8'h20, 0, "R2 address ignored");
    do_stop();
    chk(busy === 0, "R2 no write", busy, 0);

    // R4, R5: byte write, polling during the write cycle
    do_start();
    send(sel_byte(PINS, 0), 1, "R4 select");
    send(8'h35, 1, "R4 address");
    send(8'h5A, 1, "R4 data");
    exp_mem[8'h35] = 8'h5A;
    do_stop();
    chk(busy === 1, "R5 busy after stop", busy, 1);
    do_start();
    send(sel_byte(PINS, 0), 0, "R5 poll nack while busy");
    repeat (BUSY_LEN) @(negedge clk);
    chk(busy === 0, "R5 busy ends", busy, 0);
    // R6: current-address read after the write
    do_start();
    send(sel_byte(PINS, 1), 1, "R6 select");
    rd(0, exp_mem[8'h36], "R6 current read");
    do_stop();
    rand_read(8'h35, 1, "R4 byte stored");

    // R4: page write wraps inside the page
    page_write(8'h4E, 5, "R4 page wrap");
    rand_read(8'h4E, 2, "R4 wrap tail");
    rand_read(8'h40, 4, "R4 wrap head");
    chk(exp_mem[8'h50] === 8'hFF, "R4 next page untouched", exp_mem[8'h50], 8'hFF);
    rand_read(8'h50, 1, "R4 next page read");

    // R6: current read continues from the counter
    do_start();
    send(sel_byte(PINS, 1), 1, "R6 select 2");
    rd(0, exp_mem[exp_addr], "R6 counter read");
    do_stop();

    // R8: rollover across FFh
    page_write(8'hFF, 1, "R8 seed FF");
    page_write(8'h00, 1, "R8 seed 00");
    rand_read(8'hFE, 3, "R8 rollover");

    // R9: master no-acknowledge ends the read
    do_start();
    send(sel_byte(PINS, 1), 1, "R9 select");
    rd(0, exp_mem[exp_addr], "R9 last byte");
    no_tx("R9 no tx after nack");
    send(8'h12, 0, "R9 byte ignored");
    do_stop();

    // R10: protected lower half, free upper half
    wp_en = 1;
    page_write(8'h20, 2, "R10 protected");
    rand_read(8'h20, 2, "R10 lower unchanged");
    page_write(8'h90, 2, "R10 upper written");
    rand_read(8'h90, 2, "R10 upper read");
    wp_en = 0;

    // R5: stop after the address only
    do_start();
    send(sel_byte(PINS, 0), 1, "R5 select");
    send(8'h70, 1, "R5 address only");
    do_stop();
    chk(busy === 0, "R5 no cycle without data", busy, 0);

    // R7: repeated start discards buffered data
    do_start();
    send(sel_byte(PINS, 0), 1, "R7 select");
    send(8'h60, 1, "R7 address");
    send(8'h77, 1, "R7 data");
    do_start();
    chk(busy === 0, "R7 no write on restart", busy, 0);
    send(sel_byte(PINS, 1), 1, "R7 read select");
    rd(0, exp_mem[8'h61], "R7 read after data");
    do_stop();
    rand_read(8'h60, 1, "R7 data discarded");

    // Random page writes and read-back
    for (int k = 0; k < 24; k++) begin
      logic [7:0] a;
      a = 8'($urandom);
      page_write(a, 1 + int'($urandom_range(19)), "R4 random write");
      rand_read(8'($urandom), 1 + int'($urandom_range(5)), "R8 random read");
      rand_read(a, 2, "R4 random readback");
    end

    summary();
  end
endmodule